// File: doc/BRIEF.md
# Fan PWM Generator with Selectable Base Clock

This block drives up to three fan PWM outputs from one fast input clock, nominally 48 MHz. A byte-wide register port sets everything. One shared mode register holds a per-fan enable bit, a 3-bit code that picks the PWM base clock from a fixed set of divide ratios, and one global polarity bit. Each fan also has an 8-bit duty register and a control register. Bit 7 of that control register selects automatic or software control, but only software control is built. In software control the duty value sets the output directly.

Each PWM period lasts 256 base-clock ticks. The output is active for exactly as many ticks as the duty value, so a duty of 0 gives a constant inactive level. A new duty value is taken up only at a period boundary, so the output never shows a shortened or split pulse. When the clock-select code changes, the prescaler and the period counter restart from zero and the current duty values are loaded at once. The enable bits for smart mode and the tachometers are stored and read back but have no effect on the outputs.

Top module: `fanpwm_top`

## Requirements
- R1: After reset every register reads 0 and every fan output is 1, which is the inactive level for polarity 0. Reads are combinational from `addr`. The address map is: 0x00 mode, 0x01 main control, 0x10+i duty of fan i+1, 0x18+i control of fan i+1. Main control keeps only bits 0-2 and 4-6, so a write of 0xFF reads back 0x77. A fan control register keeps only bit 7, so a write of 0xFF reads back 0x80. An unmapped address reads 0 and ignores writes.
- R2: Mode bit 7 sets the polarity. With 1 the active level is 1; with 0 the active level is 0 and the inactive level is 1.
- R3: Mode bits 0, 1 and 2 enable fans 1, 2 and 3. A disabled fan holds its inactive level.
- R4: Mode bits 6:4 select the base-clock divide ratio: code 0 → 1, 1 → 2, 3 → 6, 4 → 8, 5 → 16, 6 → 32, 7 → 938. Code 2 is reserved, behaves as divide-by-1 and reads back as written.
- R5: A period is 256 base-clock ticks. An enabled fan is active for exactly `duty` ticks of each period: duty 0 gives a constant inactive level, and duty 255 leaves one inactive tick per period.
- R6: A duty write takes effect only at the next period boundary. Until then the output keeps the duty value that was loaded before.
- R7: A write that changes the clock-select code restarts the prescaler and the period counter from zero and loads every fan's duty value. The first active pulse then lasts exactly `duty` times the divide ratio in input clocks.
- R8: Bit 7 of a fan control register (automatic mode) is stored but has no effect on that fan's output.
- R9: The main control bits (smart-mode enables at bits 0-2, tachometer enables at bits 4-6) are stored but have no effect on any fan output.
- R10: Fans are independent: each follows its own duty register and enable bit, and all share the same period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock (nominally 48 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the byte register port |
| addr | input | 8 | Register address for both write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| fan_pwm | output | NUM_FANS | PWM outputs, bit 0 is fan 1 |

## Verification
The bench counts active cycles over exactly one period for each divide ratio and each polarity. A wrong divisor or a wrong active-count comparison (one tick too many, or a stray pulse at duty 0) shows up as a count that is off by one tick or more. It changes the duty in the middle of a period after a known restart. A design that applies the value at once would turn the output active in the second half of the period. It measures the first pulse after switching to the slowest clock. A design that fails to restart on a code change, or that uses the wrong divisor for code 7, would give a pulse length other than 938 cycles. Stored-only bits such as the automatic-mode bit, the reserved clock code and the register masks are checked both on readback and through the measured outputs.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int PERIOD_W = 8;

    localparam logic [ADDR_W-1:0] A_MODE  = 8'h00;
    localparam logic [ADDR_W-1:0] A_MAIN  = 8'h01;
    localparam logic [ADDR_W-1:0] A_DUTY0 = 8'h10;
    localparam logic [ADDR_W-1:0] A_FCTL0 = 8'h18;

    localparam logic [DATA_W-1:0] MAIN_MASK = 8'h77;
    localparam logic [DATA_W-1:0] FCTL_MASK = 8'h80;

    typedef enum logic [2:0] {
        CK_DIV1   = 3'd0,
        CK_DIV2   = 3'd1,
        CK_RSVD   = 3'd2,
        CK_DIV6   = 3'd3,
        CK_DIV8   = 3'd4,
        CK_DIV16  = 3'd5,
        CK_DIV32  = 3'd6,
        CK_SLOW   = 3'd7
    } clk_sel_e;
endpackage

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
    import fanpwm_pkg::*;
#(
    parameter int NUM_FANS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [DATA_W-1:0]            rd_data,
    output logic [DATA_W-1:0]            mode,
    output logic [NUM_FANS*DATA_W-1:0]   duty,
    output logic                         restart
);
    typedef struct packed {
        logic [DATA_W-1:0]                   mode;
        logic [DATA_W-1:0]                   main;
        logic [NUM_FANS-1:0][DATA_W-1:0]     duty;
        logic [NUM_FANS-1:0][DATA_W-1:0]     fctl;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == A_MODE) st_d.mode = wr_data;
            if (addr == A_MAIN) st_d.main = wr_data & MAIN_MASK;
            for (int i = 0; i < NUM_FANS; i++) begin
                if (addr == A_DUTY0 + ADDR_W'(i)) st_d.duty[i] = wr_data;
                if (addr == A_FCTL0 + ADDR_W'(i)) st_d.fctl[i] = wr_data & FCTL_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // A change of the clock-select code restarts the timing chain.
    assign restart = wr_en && (addr == A_MODE) && (wr_data[6:4] != st_q.mode[6:4]);

    always_comb begin
        rd_data = '0;
        if (addr == A_MODE) rd_data = st_q.mode;
        if (addr == A_MAIN) rd_data = st_q.main;
        for (int i = 0; i < NUM_FANS; i++) begin
            if (addr == A_DUTY0 + ADDR_W'(i)) rd_data = st_q.duty[i];
            if (addr == A_FCTL0 + ADDR_W'(i)) rd_data = st_q.fctl[i];
        end
    end

    assign mode = st_q.mode;
    assign duty = st_q.duty;
endmodule

// File: rtl/fanpwm_prescale.sv
module fanpwm_prescale
    import fanpwm_pkg::*;
#(
    parameter int SLOW_DIV = 938
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       restart,
    output logic       tick
);
    localparam int PRE_W = $clog2(SLOW_DIV);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic [PRE_W-1:0] div_m1;

    always_comb begin
        unique case (clk_sel_e'(sel))
            CK_DIV2:  div_m1 = PRE_W'(1);
            CK_DIV6:  div_m1 = PRE_W'(5);
            CK_DIV8:  div_m1 = PRE_W'(7);
            CK_DIV16: div_m1 = PRE_W'(15);
            CK_DIV32: div_m1 = PRE_W'(31);
            CK_SLOW:  div_m1 = PRE_W'(SLOW_DIV - 1);
            default:  div_m1 = '0;
        endcase
    end

    assign tick = (st_q.cnt == div_m1);

    always_comb begin
        st_d = st_q;
        if (restart || tick) st_d.cnt = '0;
        else                 st_d.cnt = st_q.cnt + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fanpwm_period.sv
module fanpwm_period
    import fanpwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                restart,
    output logic [PERIOD_W-1:0] cnt,
    output logic                wrap
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
    } per_t;

    per_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart)   st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + PERIOD_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign wrap = tick && (st_q.cnt == '1);
endmodule

// File: rtl/fanpwm_channel.sv
module fanpwm_channel
    import fanpwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cnt,
    input  logic                wrap,
    input  logic                restart,
    input  logic [DATA_W-1:0]   duty,
    input  logic                en,
    input  logic                pol,
    output logic [DATA_W-1:0]   live,
    output logic                pwm
);
    typedef struct packed {
        logic [DATA_W-1:0] live;
        logic              out;
    } ch_t;

    ch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Duty is taken up only at a period boundary or a restart.
        if (restart || wrap) st_d.live = duty;
        st_d.out = (en && (cnt < st_q.live)) ? pol : ~pol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.live <= '0;
            st_q.out  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign live = st_q.live;
    assign pwm  = st_q.out;
endmodule

// File: rtl/fanpwm_top.sv
module fanpwm_top
    import fanpwm_pkg::*;
#(
    parameter int NUM_FANS = 3,
    parameter int SLOW_DIV = 938
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          addr,
    input  logic [7:0]          wr_data,
    output logic [7:0]          rd_data,
    output logic [NUM_FANS-1:0] fan_pwm
);
    logic [DATA_W-1:0]          mode_q;
    logic [NUM_FANS*DATA_W-1:0] duty_q;
    logic [NUM_FANS*DATA_W-1:0] live_duty;
    logic                       restart;
    logic                       tick;
    logic                       wrap;
    logic [PERIOD_W-1:0]        period_cnt;
    logic [NUM_FANS-1:0]        fan_en;
    logic                       pol_hi;

    assign fan_en = mode_q[NUM_FANS-1:0];
    assign pol_hi = mode_q[7];

    fanpwm_regs #(.NUM_FANS(NUM_FANS)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .mode    (mode_q),
        .duty    (duty_q),
        .restart (restart)
    );

    fanpwm_prescale #(.SLOW_DIV(SLOW_DIV)) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (mode_q[6:4]),
        .restart (restart),
        .tick    (tick)
    );

    fanpwm_period per_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .cnt     (period_cnt),
        .wrap    (wrap)
    );

    for (genvar i = 0; i < NUM_FANS; i++) begin : g_ch
        fanpwm_channel ch_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (period_cnt),
            .wrap    (wrap),
            .restart (restart),
            .duty    (duty_q[i*DATA_W +: DATA_W]),
            .en      (fan_en[i]),
            .pol     (pol_hi),
            .live    (live_duty[i*DATA_W +: DATA_W]),
            .pwm     (fan_pwm[i])
        );
    end
endmodule

// File: rtl/fanpwm_chk.sv
module fanpwm_chk
    import fanpwm_pkg::*;
#(
    parameter int NUM_FANS = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [7:0]                 addr,
    input logic [7:0]                 rd_data,
    input logic                       restart,
    input logic                       tick,
    input logic                       wrap,
    input logic [PERIOD_W-1:0]        cnt,
    input logic [NUM_FANS-1:0]        en,
    input logic                       pol,
    input logic [NUM_FANS*DATA_W-1:0] live,
    input logic [NUM_FANS-1:0]        pwm
);
    // R1: bits outside the kept fields of main control read as zero
    a_r1_main_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_MAIN) |-> (rd_data[3] == 1'b0 && rd_data[7] == 1'b0));

    // R5: the period counter only moves on a base-clock tick or a restart
    a_r5_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cnt) |-> $past(tick || restart));

    for (genvar i = 0; i < NUM_FANS; i++) begin : g_fan
        // R3: a disabled fan drives the inactive level
        a_r3_off_inactive: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |=> (pwm[i] == ~$past(pol)));

        // R5: a loaded duty of zero never produces an active cycle
        a_r5_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
            (live[i*DATA_W +: DATA_W] == '0) |=> (pwm[i] == ~$past(pol)));

        // R6: the loaded duty changes only at a boundary or restart
        a_r6_boundary_load: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(live[i*DATA_W +: DATA_W]) |-> $past(wrap || restart));
    end
endmodule

bind fanpwm_top fanpwm_chk #(.NUM_FANS(NUM_FANS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rd_data (rd_data),
    .restart (restart),
    .tick    (tick),
    .wrap    (wrap),
    .cnt     (period_cnt),
    .en      (fan_en),
    .pol     (pol_hi),
    .live    (live_duty),
    .pwm     (fan_pwm)
);

// File: tb/fanpwm_tb.sv
module fanpwm_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 3;
    localparam int NVEC = 10;

    // {mode, duty of fan 1, expected count of cycles at 1 in one period}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h81, 8'h80, 16'd128},   // R5 code 0, pol high
        {8'h91, 8'h40, 16'd128},   // R4 div 2
        {8'hB1, 8'h10, 16'd96},    // R4 div 6
        {8'hC1, 8'h03, 16'd24},    // R4 div 8
        {8'hA1, 8'h20, 16'd32},    // R4 reserved code acts as div 1
        {8'h01, 8'h30, 16'd208},   // R2 active low
        {8'h80, 8'h80, 16'd0},     // R3 off, pol high
        {8'h00, 8'h80, 16'd256},   // R3 off, pol low
        {8'h81, 8'h00, 16'd0},     // R5 duty 0
        {8'h81, 8'hFF, 16'd255}    // R5 duty 255
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = 8'h00;
    logic [7:0]    wr_data = 8'h00;
    logic [7:0]    rd_data;
    logic [NF-1:0] fan_pwm;

    int checks = 0;
    int errors = 0;

    fanpwm_top #(.NUM_FANS(NF), .SLOW_DIV(938)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .fan_pwm (fan_pwm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ref_div(input logic [2:0] code);
        case (code)
            3'd1: return 2;
            3'd3: return 6;
            3'd4: return 8;
            3'd5: return 16;
            3'd6: return 32;
            3'd7: return 938;
            default: return 1;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic high_count(input int f, input int n, output int hi);
        hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (fan_pwm[f]) hi++;
        end
    endtask

    task automatic pulse_len(input int f, input logic lvl, output int len);
        len = 0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (fan_pwm[f] != lvl) break;
            len++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int hi;
        int w;

        repeat (3) @(negedge clk);
        // R1 reset state
        #1 check("R1 reset pwm", int'(fan_pwm), 7);
        rst_n = 1'b1;
        rd(8'h00, d); check("R1 reset mode", int'(d), 0);

        // R1 register masks and unmapped address
        wr(8'h01, 8'hFF); rd(8'h01, d); check("R1 main mask", int'(d), 8'h77);
        wr(8'h18, 8'hFF); rd(8'h18, d); check("R1 fctl mask", int'(d), 8'h80);
        wr(8'h05, 8'hAA); rd(8'h05, d); check("R1 unmapped", int'(d), 0);
        wr(8'h00, 8'hA1); rd(8'h00, d); check("R4 reserved readback", int'(d), 8'hA1);

        // R8 R9: auto bit and main bits stored, no effect on output
        wr(8'h10, 8'h80);
        wr(8'h00, 8'h81);
        repeat (600) @(negedge clk);
        high_count(0, 256, hi);
        check("R8 R9 stored bits ignored", hi, 128);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            wr(8'h10, VEC[v][23:16]);
            wr(8'h00, VEC[v][31:24]);
            w = 256 * ref_div(VEC[v][30:28]);
            repeat (2 * w + 4) @(negedge clk);
            high_count(0, w, hi);
            check($sformatf("R2 R3 R4 R5 vec %0d", v), hi, int'(VEC[v][15:0]));
        end

        // R6: duty update waits for the period boundary
        wr(8'h00, 8'h81);
        wr(8'h10, 8'h40);
        wr(8'h00, 8'h91);
        wr(8'h00, 8'h81);
        wr(8'h10, 8'hC0);
        repeat (120) @(negedge clk);
        check("R6 mid-period hold", int'(fan_pwm[0]), 0);
        repeat (200) @(negedge clk);
        high_count(0, 256, hi);
        check("R6 new duty next period", hi, 192);

        // R7: restart on code change, first pulse length
        wr(8'h10, 8'h01);
        repeat (600) @(negedge clk);
        wr(8'h00, 8'hF1);
        pulse_len(0, 1'b1, hi);
        check("R7 slow first pulse", hi, 938);
        wr(8'h00, 8'h81);
        pulse_len(0, 1'b1, hi);
        check("R7 div1 first pulse", hi, 1);

        // R10: fans independent
        wr(8'h10, 8'hFF);
        wr(8'h11, 8'h40);
        wr(8'h12, 8'hA0);
        wr(8'h00, 8'h86);
        repeat (600) @(negedge clk);
        high_count(0, 256, hi); check("R10 fan1 off", hi, 0);
        high_count(1, 256, hi); check("R10 fan2 duty", hi, 64);
        high_count(2, 256, hi); check("R10 fan3 duty", hi, 160);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule